// File: doc/BRIEF.md
# Memory Size Autoprobe Engine

This block is a small bus master that finds out at run time whether a RAM device answers inside an address window and, if it does, how many bytes it holds. It drives a word-addressed memory port with an address, write data, separate read and write strobes and a ready handshake. Software or a boot sequencer gives it a base byte address and an upper bound on the size, both powers of two, and pulses start. When the engine has finished it returns the size in bytes, or zero when nothing usable is there, together with a one-cycle done pulse.

The search works by address wraparound. The engine reads the word at a growing power-of-two offset. It writes the complement of that word to offset zero and reads both places again. If the two reads agree, the two addresses reach the same storage and the offset is the device size. Only the two words at the head of the window are ever written. Their original contents are saved first and written back before done, so data kept further up the window, such as a battery-backed store, is never touched.

Top module: `msp_autoprobe`

## Requirements
- R1: While reset is held and afterwards until a start is accepted, done is low, no read or write strobe is raised and the reported size is 0.
- R2: The words at byte offsets 0 and 4 of the window are read and kept before any write. Both are written back before done rises, so every word in the window holds its original value after the probe.
- R3: A presence check runs first, in two passes. Pass one writes 0x5555AAAA at offset 0 and 0xAAAA5555 at offset 4, then reads offset 0. Pass two swaps the two patterns. If either read-back differs from the word written at offset 0, the size reported is 0. This covers a bus that returns the last driven value, a bus that floats high, and a stuck data bit.
- R4: The search starts at offset 4 and doubles the offset after each step. For a device that aliases every S bytes, with S smaller than the maximum, the reported size is S.
- R5: When the offset reaches the maximum without any wrap being seen, the reported size equals the maximum size.
- R6: Every write issued by the engine targets byte offset 0 or byte offset 4 of the window.
- R7: A raised strobe keeps its address, data and direction unchanged until a cycle in which ready is high, and read and write are never raised together.
- R8: A start seen while a probe is running, including the cycle in which done is high, is ignored: no further bus traffic and no second done follow.
- R9: done is high for exactly one cycle per probe, and the reported size changes only in the cycle where done is high.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock, rising edge active |
| rst_n | input | 1 | Asynchronous reset, active low |
| start | input | 1 | Begins a probe when the engine is idle |
| base_addr | input | AW | Byte address of the window, aligned to max_size |
| max_size | input | AW | Upper bound of the search in bytes, a power of two, at least 8 |
| mem_addr | output | AW-2 | Word address of the current access |
| mem_we | output | 1 | Write strobe, held until ready |
| mem_re | output | 1 | Read strobe, held until ready |
| mem_wdata | output | DW | Write data |
| mem_rdata | input | DW | Read data, sampled in the cycle where ready is high |
| mem_ready | input | 1 | Completes the current access |
| size_bytes | output | AW | Size found by the last probe, 0 when absent or faulty |
| done | output | 1 | One-cycle pulse when a probe is over |

## Verification
Two events can share one clock. A start can arrive in the same cycle that done is high, and a fresh strobe can be completed by ready in the very cycle it is raised. The bench raises start in the done cycle of every probe, then watches the port for idle cycles. It also raises start in the middle of a run, so a restart would show up as extra traffic or a changed result. Each sweep is run once with ready held high, which gives zero-wait accesses, and once with ready arriving every third cycle. The check is that the size returned and the restored window contents are the same in both runs.

// File: rtl/msp_pkg.sv
package msp_pkg;

  typedef enum logic [4:0] {
    S_IDLE, S_SV0, S_SV1,
    S_A0, S_A1, S_AR,
    S_B0, S_B1, S_BR,
    S_CHK, S_ST, S_SC, S_SR0, S_SR1,
    S_RS0, S_RS1, S_FIN
  } st_t;

  typedef enum logic [1:0] {LOC_ZERO, LOC_FOUR, LOC_PROBE} loc_t;

  typedef enum logic [2:0] {WD_PA, WD_PB, WD_NOT_T, WD_SAVE0, WD_SAVE1} wsrc_t;

  // Upper half 0101..., lower half 1010... of a w-bit word (w <= 64).
  function automatic logic [63:0] alt_pattern(input int w);
    logic [63:0] p;
    p = '0;
    for (int i = 0; i < 64; i++) begin
      if (i < w) p[i] = (i < w / 2) ? i[0] : ~i[0];
    end
    return p;
  endfunction

  function automatic logic [63:0] next_offset(input logic [63:0] ofs);
    return ofs << 1;
  endfunction

endpackage

// File: rtl/msp_offset_gen.sv
module msp_offset_gen #(
  parameter int AW = 32
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          load,
  input  logic          step,
  input  logic [AW-1:0] limit,
  output logic [AW-1:0] ofs,
  output logic          at_limit
);
  import msp_pkg::*;

  localparam logic [AW-1:0] FIRST_OFS = AW'(4);

  logic [63:0] nxt_wide;
  assign nxt_wide = next_offset(64'(ofs));

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)    ofs <= FIRST_OFS;
    else if (load) ofs <= FIRST_OFS;
    else if (step) ofs <= nxt_wide[AW-1:0];
  end

  assign at_limit = (ofs >= limit);

endmodule

// File: rtl/msp_bus_port.sv
module msp_bus_port #(
  parameter int AW = 32,
  parameter int DW = 32
) (
  input  msp_pkg::loc_t  loc,
  input  msp_pkg::wsrc_t wsrc,
  input  logic           op_rd,
  input  logic           op_wr,
  input  logic [AW-3:0]  base_w,
  input  logic [AW-1:0]  ofs,
  input  logic [DW-1:0]  save0,
  input  logic [DW-1:0]  save1,
  input  logic [DW-1:0]  t_word,
  input  logic           mem_ready,
  output logic [AW-3:0]  mem_addr,
  output logic           mem_we,
  output logic           mem_re,
  output logic [DW-1:0]  mem_wdata,
  output logic           xfer
);
  import msp_pkg::*;

  localparam logic [63:0] PAT_WIDE = alt_pattern(DW);
  localparam logic [DW-1:0] PAT_A = PAT_WIDE[DW-1:0];
  localparam logic [DW-1:0] PAT_B = ~PAT_A;

  logic [AW-3:0] ofs_w;
  logic          unused_ofs_lo;
  assign unused_ofs_lo = ^ofs[1:0];

  always_comb begin
    unique case (loc)
      LOC_FOUR:  ofs_w = (AW-2)'(1);
      LOC_PROBE: ofs_w = ofs[AW-1:2];
      default:   ofs_w = '0;
    endcase
  end

  always_comb begin
    unique case (wsrc)
      WD_PB:    mem_wdata = PAT_B;
      WD_NOT_T: mem_wdata = ~t_word;
      WD_SAVE0: mem_wdata = save0;
      WD_SAVE1: mem_wdata = save1;
      default:  mem_wdata = PAT_A;
    endcase
  end

  assign mem_addr = base_w + ofs_w;
  assign mem_we   = op_wr;
  assign mem_re   = op_rd;
  assign xfer     = (op_rd | op_wr) & mem_ready;

endmodule

// File: rtl/msp_fsm.sv
module msp_fsm #(
  parameter int AW = 32,
  parameter int DW = 32
) (
  input  logic           clk,
  input  logic           rst_n,
  input  logic           start,
  input  logic [AW-1:0]  base_addr,
  input  logic [AW-1:0]  max_size,
  input  logic           xfer,
  input  logic [DW-1:0]  rdata,
  input  logic [AW-1:0]  ofs,
  input  logic           at_limit,
  output msp_pkg::st_t   state,
  output logic           op_rd,
  output logic           op_wr,
  output msp_pkg::loc_t  loc,
  output msp_pkg::wsrc_t wsrc,
  output logic           ofs_load,
  output logic           ofs_step,
  output logic [AW-3:0]  base_w,
  output logic [AW-1:0]  max_q,
  output logic [DW-1:0]  save0,
  output logic [DW-1:0]  save1,
  output logic [DW-1:0]  t_q,
  output logic [AW-1:0]  size_bytes,
  output logic           done,
  output logic           launch,
  output logic           presence_fail,
  output logic           wrap_hit
);
  import msp_pkg::*;

  localparam logic [63:0] PAT_WIDE = alt_pattern(DW);
  localparam logic [DW-1:0] PAT_A = PAT_WIDE[DW-1:0];
  localparam logic [DW-1:0] PAT_B = ~PAT_A;

  st_t           nxt;
  logic [DW-1:0] b_q;
  logic [AW-1:0] found_q;
  logic          rd_mismatch;
  logic          limit_hit;
  logic          unused_base_lo;
  assign unused_base_lo = ^base_addr[1:0];

  assign launch        = (state == S_IDLE) && start;
  assign done          = (state == S_FIN);
  assign rd_mismatch   = (state == S_AR) ? (rdata != PAT_A) : (rdata != PAT_B);
  assign presence_fail = xfer && ((state == S_AR) || (state == S_BR)) && rd_mismatch;
  assign wrap_hit      = xfer && (state == S_SR1) && (rdata == b_q);
  assign limit_hit     = (state == S_CHK) && at_limit;
  assign ofs_load      = launch;
  assign ofs_step      = xfer && (state == S_SR1) && !wrap_hit;

  always_comb begin
    nxt   = state;
    op_rd = 1'b0;
    op_wr = 1'b0;
    loc   = LOC_ZERO;
    wsrc  = WD_PA;
    unique case (state)
      S_IDLE: if (start) nxt = S_SV0;
      S_SV0:  begin op_rd = 1'b1; if (xfer) nxt = S_SV1; end
      S_SV1:  begin op_rd = 1'b1; loc = LOC_FOUR; if (xfer) nxt = S_A0; end
      S_A0:   begin op_wr = 1'b1; wsrc = WD_PA; if (xfer) nxt = S_A1; end
      S_A1:   begin op_wr = 1'b1; loc = LOC_FOUR; wsrc = WD_PB; if (xfer) nxt = S_AR; end
      S_AR:   begin op_rd = 1'b1; if (xfer) nxt = rd_mismatch ? S_RS0 : S_B0; end
      S_B0:   begin op_wr = 1'b1; wsrc = WD_PB; if (xfer) nxt = S_B1; end
      S_B1:   begin op_wr = 1'b1; loc = LOC_FOUR; wsrc = WD_PA; if (xfer) nxt = S_BR; end
      S_BR:   begin op_rd = 1'b1; if (xfer) nxt = rd_mismatch ? S_RS0 : S_CHK; end
      S_CHK:  nxt = at_limit ? S_RS0 : S_ST;
      S_ST:   begin op_rd = 1'b1; loc = LOC_PROBE; if (xfer) nxt = S_SC; end
      S_SC:   begin op_wr = 1'b1; wsrc = WD_NOT_T; if (xfer) nxt = S_SR0; end
      S_SR0:  begin op_rd = 1'b1; if (xfer) nxt = S_SR1; end
      S_SR1:  begin
                op_rd = 1'b1; loc = LOC_PROBE;
                if (xfer) nxt = (rdata == b_q) ? S_RS0 : S_CHK;
              end
      S_RS0:  begin op_wr = 1'b1; wsrc = WD_SAVE0; if (xfer) nxt = S_RS1; end
      S_RS1:  begin op_wr = 1'b1; loc = LOC_FOUR; wsrc = WD_SAVE1; if (xfer) nxt = S_FIN; end
      S_FIN:  nxt = S_IDLE;
      default: nxt = S_IDLE;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) state <= S_IDLE;
    else        state <= nxt;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      base_w <= '0;
      max_q  <= '0;
    end else if (launch) begin
      base_w <= base_addr[AW-1:2];
      max_q  <= max_size;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      save0 <= '0;
      save1 <= '0;
      t_q   <= '0;
      b_q   <= '0;
    end else if (xfer) begin
      if (state == S_SV0) save0 <= rdata;
      if (state == S_SV1) save1 <= rdata;
      if (state == S_ST)  t_q   <= rdata;
      if (state == S_SR0) b_q   <= rdata;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)             found_q <= '0;
    else if (launch)        found_q <= '0;
    else if (presence_fail) found_q <= '0;
    else if (limit_hit)     found_q <= max_q;
    else if (wrap_hit)      found_q <= ofs;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)                          size_bytes <= '0;
    else if (xfer && (state == S_RS1))   size_bytes <= found_q;
  end

endmodule

// File: rtl/msp_autoprobe.sv
module msp_autoprobe #(
  parameter int AW = 32,
  parameter int DW = 32
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          start,
  input  logic [AW-1:0] base_addr,
  input  logic [AW-1:0] max_size,
  output logic [AW-3:0] mem_addr,
  output logic          mem_we,
  output logic          mem_re,
  output logic [DW-1:0] mem_wdata,
  input  logic [DW-1:0] mem_rdata,
  input  logic          mem_ready,
  output logic [AW-1:0] size_bytes,
  output logic          done
);
  import msp_pkg::*;

  st_t           state;
  loc_t          loc;
  wsrc_t         wsrc;
  logic          op_rd, op_wr, xfer;
  logic          ofs_load, ofs_step, at_limit;
  logic [AW-1:0] ofs, max_q;
  logic [AW-3:0] base_w;
  logic [DW-1:0] save0, save1, t_q;
  logic          launch, presence_fail, wrap_hit;

  msp_fsm #(.AW(AW), .DW(DW)) u_fsm (
    .clk(clk), .rst_n(rst_n), .start(start),
    .base_addr(base_addr), .max_size(max_size),
    .xfer(xfer), .rdata(mem_rdata), .ofs(ofs), .at_limit(at_limit),
    .state(state), .op_rd(op_rd), .op_wr(op_wr), .loc(loc), .wsrc(wsrc),
    .ofs_load(ofs_load), .ofs_step(ofs_step),
    .base_w(base_w), .max_q(max_q),
    .save0(save0), .save1(save1), .t_q(t_q),
    .size_bytes(size_bytes), .done(done),
    .launch(launch), .presence_fail(presence_fail), .wrap_hit(wrap_hit)
  );

  msp_offset_gen #(.AW(AW)) u_ofs (
    .clk(clk), .rst_n(rst_n), .load(ofs_load), .step(ofs_step),
    .limit(max_q), .ofs(ofs), .at_limit(at_limit)
  );

  msp_bus_port #(.AW(AW), .DW(DW)) u_bus (
    .loc(loc), .wsrc(wsrc), .op_rd(op_rd), .op_wr(op_wr),
    .base_w(base_w), .ofs(ofs),
    .save0(save0), .save1(save1), .t_word(t_q),
    .mem_ready(mem_ready),
    .mem_addr(mem_addr), .mem_we(mem_we), .mem_re(mem_re),
    .mem_wdata(mem_wdata), .xfer(xfer)
  );

endmodule

// File: rtl/msp_checker.sv
module msp_checker #(
  parameter int AW = 32,
  parameter int DW = 32
) (
  input logic          clk,
  input logic          rst_n,
  input logic [AW-3:0] mem_addr,
  input logic          mem_we,
  input logic          mem_re,
  input logic [DW-1:0] mem_wdata,
  input logic          mem_ready,
  input logic [AW-1:0] size_bytes,
  input logic          done,
  input logic [AW-3:0] base_w,
  input logic          wrap_hit,
  input logic [AW-1:0] ofs,
  input logic [AW-1:0] max_q
);

  AST_RW_EXCLUSIVE: assert property (@(posedge clk) disable iff (!rst_n)
    !(mem_we && mem_re)); // R7

  AST_REQ_HELD: assert property (@(posedge clk) disable iff (!rst_n)
    ((mem_we || mem_re) && !mem_ready) |=>
      ($stable(mem_addr) && $stable(mem_we) && $stable(mem_re) && $stable(mem_wdata))); // R7

  AST_DONE_ONE_CYCLE: assert property (@(posedge clk) disable iff (!rst_n)
    done |=> !done); // R9

  AST_SIZE_ONLY_AT_DONE: assert property (@(posedge clk) disable iff (!rst_n)
    (size_bytes != $past(size_bytes)) |-> done); // R9

  AST_WRITE_IN_HEAD: assert property (@(posedge clk) disable iff (!rst_n)
    mem_we |-> ((mem_addr == base_w) || (mem_addr == base_w + (AW-2)'(1)))); // R6

  AST_IDLE_AFTER_DONE: assert property (@(posedge clk) disable iff (!rst_n)
    done |=> (!mem_we && !mem_re)); // R8

  AST_WRAP_BELOW_MAX: assert property (@(posedge clk) disable iff (!rst_n)
    wrap_hit |-> (ofs < max_q)); // R4

endmodule

bind msp_autoprobe msp_checker #(.AW(AW), .DW(DW)) u_msp_checker (
  .clk(clk), .rst_n(rst_n), .mem_addr(mem_addr), .mem_we(mem_we),
  .mem_re(mem_re), .mem_wdata(mem_wdata), .mem_ready(mem_ready),
  .size_bytes(size_bytes), .done(done), .base_w(base_w),
  .wrap_hit(wrap_hit), .ofs(ofs), .max_q(max_q)
);

// File: tb/test_msp_autoprobe.sv
`timescale 1ns/1ps
module test_msp_autoprobe;
  localparam int AW = 12;
  localparam int DW = 32;

  logic          clk = 1'b0;
  logic          rst_n = 1'b0;
  logic          start = 1'b0;
  logic [AW-1:0] base_addr = '0;
  logic [AW-1:0] max_size = '0;
  logic [AW-3:0] mem_addr;
  logic          mem_we, mem_re;
  logic [DW-1:0] mem_wdata;
  logic [DW-1:0] mem_rdata;
  logic          mem_ready = 1'b1;
  logic [AW-1:0] size_bytes;
  logic          done;

  int errors = 0;
  int checks = 0;

  // model: 0 aliasing RAM, 1 bus keeps last driven value, 2 floating high, 3 RAM with bit0 stuck low
  int            cur_model = 0;
  int            cur_words = 2;
  int            wait_mode = 0;
  int            cyc = 0;
  int            wr_viol = 0;
  int            hold_viol = 0;
  logic [AW-3:0] base_w = '0;
  logic [DW-1:0] mem [64];
  logic [DW-1:0] last_w = '0;
  int            idx;

  always #4 clk = ~clk;

  msp_autoprobe #(.AW(AW), .DW(DW)) i_msp_autoprobe (
    .clk(clk), .rst_n(rst_n), .start(start),
    .base_addr(base_addr), .max_size(max_size),
    .mem_addr(mem_addr), .mem_we(mem_we), .mem_re(mem_re),
    .mem_wdata(mem_wdata), .mem_rdata(mem_rdata), .mem_ready(mem_ready),
    .size_bytes(size_bytes), .done(done)
  );

  function automatic logic [DW-1:0] init_word(input int i);
    return 32'h1357_0000 + 32'(i) * 32'h0102_0409;
  endfunction

  always_comb begin
    idx = int'((mem_addr - base_w)) & (cur_words - 1);
    case (cur_model)
      1:       mem_rdata = last_w;
      2:       mem_rdata = '1;
      default: mem_rdata = mem[idx];
    endcase
  end

  always @(posedge clk) begin
    if (mem_we && mem_ready) begin
      last_w <= mem_wdata;
      if (cur_model == 0) mem[idx] <= mem_wdata;
      if (cur_model == 3) mem[idx] <= mem_wdata & ~32'h1;
      if ((mem_addr - base_w) > 1) wr_viol <= wr_viol + 1;
    end
  end

  // handshake monitor and ready generator
  logic          pend = 1'b0;
  logic [AW-3:0] p_addr;
  logic          p_we, p_re;
  logic [DW-1:0] p_wd;
  always @(negedge clk) begin
    cyc = cyc + 1;
    if (rst_n) begin
      if (pend && (mem_addr != p_addr || mem_we != p_we || mem_re != p_re || mem_wdata != p_wd))
        hold_viol = hold_viol + 1;
      if (mem_we && mem_re) hold_viol = hold_viol + 1;
    end
    mem_ready = (wait_mode == 0) ? 1'b1 : ((cyc % 3) == 0);
    pend   = (mem_we || mem_re) && !mem_ready;
    p_addr = mem_addr; p_we = mem_we; p_re = mem_re; p_wd = mem_wdata;
  end

  task automatic check(input bit ok, input string req, input longint act, input longint exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual=0x%0h expected=0x%0h", req, act, exp);
    end
  endtask

  function automatic int exp_size(input int model, input int sz, input int mx);
    if (model != 0) return 0;
    return (sz < mx) ? sz : mx;
  endfunction

  task automatic run(input int model, input int sz, input int mx, input int base, input int wm);
    int  waited;
    bit  seen;
    bit  quiet;
    bit  intact;
    int  e;
    cur_model = model; cur_words = sz / 4; wait_mode = wm;
    base_w = AW'(base) >> 2;
    for (int i = 0; i < 64; i++) mem[i] = init_word(i);
    wr_viol = 0; hold_viol = 0;
    base_addr = AW'(base); max_size = AW'(mx);
    @(negedge clk); start = 1'b1;
    @(negedge clk); start = 1'b0;
    waited = 0; seen = 0;
    while (!seen && waited < 4000) begin
      @(negedge clk); waited++;
      if (waited == 6) start = 1'b1;        // R8: start while busy
      else if (waited == 7) start = 1'b0;
      if (done) seen = 1;
    end
    if (!seen) begin
      check(0, "R9 watchdog", waited, 0);
      return;
    end
    e = exp_size(model, sz, mx);
    if (model != 0)     check(size_bytes == AW'(e), "R3", size_bytes, e);
    else if (sz < mx)   check(size_bytes == AW'(e), "R4", size_bytes, e);
    else                check(size_bytes == AW'(e), "R5", size_bytes, e);
    // R8: start in the done cycle must be ignored
    start = 1'b1;
    @(negedge clk); start = 1'b0;
    quiet = 1;
    for (int k = 0; k < 8; k++) begin
      if (mem_we || mem_re || done) quiet = 0;
      @(negedge clk);
    end
    check(quiet, "R8", quiet, 1);
    check(size_bytes == AW'(e), "R9 size held", size_bytes, e);
    check(wr_viol == 0, "R6", wr_viol, 0);
    check(hold_viol == 0, "R7", hold_viol, 0);
    if (model == 0) begin
      intact = 1;
      for (int i = 0; i < sz / 4; i++) if (mem[i] != init_word(i)) intact = 0;
      check(intact, "R2", intact, 1);
    end
  endtask

  initial begin : wdog
    #(8 * 190000);
    errors++; checks++;
    $display("FAIL R9 global watchdog actual=%0d expected=0", cyc);
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    check(done == 1'b0 && mem_we == 1'b0 && mem_re == 1'b0, "R1 strobes", {done, mem_we, mem_re}, 0);
    check(size_bytes == '0, "R1 size", size_bytes, 0);
    rst_n = 1'b1;
    repeat (2) @(negedge clk);
    check(!done && !mem_we && !mem_re && size_bytes == '0, "R1 idle", {done, mem_we, mem_re}, 0);

    for (int wm = 0; wm < 2; wm++)
      for (int s = 3; s <= 8; s++)
        for (int m = 3; m <= 8; m++)
          run(0, 1 << s, 1 << m, ((s + m) % 3) * 32'h400, wm);

    for (int wm = 0; wm < 2; wm++) begin
      run(1, 64, 128, 32'h800, wm);  // R3 stale bus
      run(2, 64, 128, 32'h400, wm);  // R3 floating bus
      run(3, 64, 128, 32'h000, wm);  // R3 stuck bit fails second pass
    end
    // After a failed probe, a good one still works
    run(0, 32, 256, 32'h000, 1);

    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

endmodule